// File: doc/BRIEF.md
# I2C Host Register Front-End

This block sits between a simple memory-mapped CPU bus and an abstract I2C bus engine. Software writes a target address, data bytes and small command codes into byte-addressed registers. The block turns these accesses into one-at-a-time byte operations for the engine: start with address, write one byte, read one byte (which acknowledges the previous one), and stop. It does no bit timing of its own. The engine reports each finished operation with a done pulse, a not-acknowledged flag and, for reads, the received byte.

The block follows a link state (idle, writing or reading) from the outcomes of those operations. It keeps three interrupt sources (host-on-bus, client-on-bus, error), each with an enable and a pending flag. It also keeps a missing-acknowledge status bit and drives one level-sensitive interrupt line. A smart-mode option lets a read of the data register trigger the acknowledge action itself, so software needs no separate command write. Only one engine operation is outstanding at any time.

Top module: `i2c_host_regfront`

## Requirements
- R1: After reset every readable register returns 0, `irq` is 0 and `engReq` is 0.
- R2: At offset 0x00, bit 1 is the enable and bits 4:2 are the mode. A mode write is taken only for the value 5 (host); any other value keeps the old mode. Writing 1 to bit 0 returns every register of the block to its reset value, and bit 0 reads as 0. Offset 0x0C is a 32-bit read/write baud word.
- R3: A write to offset 0x24 when enable is 1, the mode is 5 and no operation is outstanding issues a start operation (`engOp` 0). Bits 10:1 give `engAddr` and bit 0 gives `engDir` (1 = read). Offset 0x24 reads back {address, direction}. The write is ignored while enable is 0.
- R4: A start that ends with `engNack` sets flag bit 0 (offset 0x18), sets status bit 2 (offset 0x1A) and leaves the link idle.
- R5: An acknowledged start clears status bit 2. It sets flag bit 0 for a write direction. For a read direction it sets flag bit 1 and loads `engRdData` as the received byte.
- R6: A write to offset 0x28 while the link is writing issues a write operation (`engOp` 1) carrying bits 7:0. Its completion sets flag bit 0. Data writes in any other link state issue nothing.
- R7: A read of offset 0x28 returns the received byte. In the reading link state the read also sets flag bit 1; in the idle state it leaves the flags unchanged.
- R8: Offset 0x04 holds smart mode at bit 8 and the ACK action at bit 18. Its command field at bits 17:16 always reads 0. The command values work as follows: 1 repeats the start with the stored address when the link is not idle; 2 issues a read operation (`engOp` 2) when reading; 3 issues a stop (`engOp` 3) when the link is not idle and always leaves it idle.
- R9: In smart mode, a data read in the reading state issues a read operation when the ACK action is 0. When the ACK action is 1 it issues a stop and the link goes idle.
- R10: Writing a 1 to bit 0, 1 or 7 of offset 0x16 sets the matching enable; writing a 1 to offset 0x14 clears it. Both offsets read back the enables at bits 0, 1 and 7.
- R11: Flag bits 0, 1 and 7 at offset 0x18 clear when 1 is written to them; bits written 0 are unchanged.
- R12: `irq` is 1 exactly when some source has both its enable and its flag set.
- R13: `engReq` stays high, with `engOp` unchanged, until `engDone`. Address, command and data writes made during that time issue nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | BUS_AW | Byte address of the register access |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe, one cycle per read |
| busWrData | input | 32 | Write data, register bits at their own positions |
| busRdData | output | 32 | Read data for busAddr, valid in the same cycle |
| engReq | output | 1 | Engine operation outstanding |
| engOp | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| engAddr | output | TGT_AW | Target address for a start |
| engDir | output | 1 | Direction for a start, 1 = read |
| engWrData | output | 8 | Byte for a write operation |
| engDone | input | 1 | One-cycle pulse ending the operation |
| engNack | input | 1 | No acknowledge seen, valid with engDone |
| engRdData | input | 8 | Received byte, valid with engDone |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults, BUS_AW = 8 and TGT_AW = 10. This makes the full 10-bit target address field and every register offset reachable. A bench engine model answers each request after a fixed latency, with a not-acknowledged flag and a read byte chosen by the bench. That lets the bench steer the link through the nack, write and read outcomes, repeated starts, smart-mode reads and stop. It can also place a second write inside the busy window to show that the write has no effect.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
  localparam int REG_W    = 32;
  localparam int BYTE_W   = 8;
  localparam int NUM_SRC  = 3;

  localparam int OFF_CTRLA  = 'h00;
  localparam int OFF_CTRLB  = 'h04;
  localparam int OFF_BAUD   = 'h0C;
  localparam int OFF_ENCLR  = 'h14;
  localparam int OFF_ENSET  = 'h16;
  localparam int OFF_FLAG   = 'h18;
  localparam int OFF_STATUS = 'h1A;
  localparam int OFF_ADDR   = 'h24;
  localparam int OFF_DATA   = 'h28;

  localparam int SMART_BIT  = 8;
  localparam int CMD_LSB    = 16;
  localparam int ACKACT_BIT = 18;
  localparam int NACK_BIT   = 2;
  localparam logic [2:0] MODE_HOST = 3'd5;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } engOp_e;

  typedef enum logic [1:0] {
    LINK_IDLE  = 2'd0,
    LINK_WRITE = 2'd1,
    LINK_READ  = 2'd2
  } link_e;

  typedef struct packed {
    logic setHost;
    logic setClient;
    logic setNack;
    logic clrNack;
    logic loadRx;
    logic swReset;
  } strobe_t;

  // bit position of interrupt source idx: host 0, client 1, error 7
  function automatic int srcPos(input int idx);
    return (idx == 0) ? 0 : (idx == 1) ? 1 : 7;
  endfunction
endpackage

// File: rtl/i2cf_ctrl.sv
module i2cf_ctrl
  import i2cf_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int TGT_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              hostReady,
  input  logic              smartEn,
  input  logic              ackAct,
  input  logic              engDone,
  input  logic              engNack,
  output logic              engReq,
  output logic [1:0]        engOp,
  output logic [TGT_AW-1:0] engAddr,
  output logic              engDir,
  output logic [BYTE_W-1:0] engWrData,
  output strobe_t           strb
);
  localparam int CMD_W = 2;

  logic   busy;
  link_e  link;
  engOp_e opQ;
  logic   issue, goIdle;
  engOp_e nextOp;
  logic   wrAddr, wrCtrlB, wrData, rdData, swr;
  logic [CMD_W-1:0] cmd;

  logic unusedWdata;
  assign unusedWdata = ^{busWrData[REG_W-1:CMD_LSB+CMD_W], busWrData[CMD_LSB-1:TGT_AW+1]};

  assign wrAddr  = busWrEn && (busAddr == BUS_AW'(OFF_ADDR));
  assign wrCtrlB = busWrEn && (busAddr == BUS_AW'(OFF_CTRLB));
  assign wrData  = busWrEn && (busAddr == BUS_AW'(OFF_DATA));
  assign rdData  = busRdEn && (busAddr == BUS_AW'(OFF_DATA));
  assign swr     = busWrEn && (busAddr == BUS_AW'(OFF_CTRLA)) && busWrData[0];
  assign cmd     = busWrData[CMD_LSB +: CMD_W];

  // request decode: one operation at a time
  always_comb begin
    issue  = 1'b0;
    goIdle = 1'b0;
    nextOp = OP_START;
    if (!busy && !swr) begin
      if (wrAddr && hostReady) begin
        issue = 1'b1;
      end else if (wrCtrlB) begin
        unique case (cmd)
          2'd1: issue = (link != LINK_IDLE);
          2'd2: begin issue = (link == LINK_READ); nextOp = OP_READ; end
          2'd3: begin goIdle = 1'b1; issue = (link != LINK_IDLE); nextOp = OP_STOP; end
          default: ;
        endcase
      end else if (wrData && link == LINK_WRITE) begin
        issue = 1'b1;
        nextOp = OP_WRITE;
      end else if (rdData && link == LINK_READ && smartEn) begin
        issue  = 1'b1;
        nextOp = ackAct ? OP_STOP : OP_READ;
        goIdle = ackAct;
      end
    end
  end

  // event strobes for the datapath
  always_comb begin
    strb = '0;
    strb.swReset = swr;
    if (busy && engDone) begin
      unique case (opQ)
        OP_START: begin
          if (engNack) begin
            strb.setHost = 1'b1;
            strb.setNack = 1'b1;
          end else begin
            strb.clrNack   = 1'b1;
            strb.setHost   = !engDir;
            strb.setClient = engDir;
            strb.loadRx    = engDir;
          end
        end
        OP_WRITE: begin
          strb.setHost = 1'b1;
          strb.setNack = engNack;
        end
        OP_READ: begin
          strb.setClient = 1'b1;
          strb.loadRx    = 1'b1;
        end
        default: ;
      endcase
    end else if (!busy && rdData && link == LINK_READ) begin
      strb.setClient = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || swr) begin
      busy      <= 1'b0;
      link      <= LINK_IDLE;
      opQ       <= OP_START;
      engAddr   <= '0;
      engDir    <= 1'b0;
      engWrData <= '0;
    end else begin
      if (busy && engDone) begin
        busy <= 1'b0;
        if (opQ == OP_START) begin
          link <= engNack ? LINK_IDLE : (engDir ? LINK_READ : LINK_WRITE);
        end
      end
      if (issue) begin
        busy <= 1'b1;
        opQ  <= nextOp;
        if (wrAddr) begin
          engAddr <= busWrData[TGT_AW:1];
          engDir  <= busWrData[0];
        end
        if (nextOp == OP_WRITE) engWrData <= busWrData[BYTE_W-1:0];
      end
      if (goIdle) link <= LINK_IDLE;
    end
  end

  assign engReq = busy;
  assign engOp  = opQ;

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engDone && !swr) |=> (engReq && $stable(engOp)));

  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && !engDone && wrAddr) |=> ($stable(engAddr) && $stable(engDir)));

  p_nack_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (engReq && engDone && engOp == 2'd0 && engNack && !swr) |=> (link == LINK_IDLE));
endmodule

// File: rtl/i2cf_datapath.sv
module i2cf_datapath
  import i2cf_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int TGT_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  input  strobe_t           strb,
  input  logic [TGT_AW-1:0] engAddr,
  input  logic              engDir,
  input  logic [BYTE_W-1:0] engRdData,
  output logic [REG_W-1:0]  busRdData,
  output logic              hostReady,
  output logic              smartEn,
  output logic              ackAct,
  output logic              irq
);
  logic             enableQ, nackQ;
  logic [2:0]       modeQ;
  logic [REG_W-1:0] baudQ;
  logic [BYTE_W-1:0] rxQ;
  logic [NUM_SRC-1:0] enQ, flagQ, setVec;
  logic [BYTE_W-1:0]  enRb, flagRb;
  logic wrCtrlA, wrCtrlB, wrBaud, wrEnSet, wrEnClr, wrFlag, clrAll;

  assign wrCtrlA = busWrEn && (busAddr == BUS_AW'(OFF_CTRLA));
  assign wrCtrlB = busWrEn && (busAddr == BUS_AW'(OFF_CTRLB));
  assign wrBaud  = busWrEn && (busAddr == BUS_AW'(OFF_BAUD));
  assign wrEnSet = busWrEn && (busAddr == BUS_AW'(OFF_ENSET));
  assign wrEnClr = busWrEn && (busAddr == BUS_AW'(OFF_ENCLR));
  assign wrFlag  = busWrEn && (busAddr == BUS_AW'(OFF_FLAG));
  assign clrAll  = !rstN || strb.swReset;

  assign setVec = {1'b0, strb.setClient, strb.setHost};

  always_ff @(posedge clk) begin
    if (clrAll) begin
      enableQ <= 1'b0;
      modeQ   <= '0;
      baudQ   <= '0;
      smartEn <= 1'b0;
      ackAct  <= 1'b0;
      nackQ   <= 1'b0;
      rxQ     <= '0;
    end else begin
      if (wrCtrlA) begin
        enableQ <= busWrData[1];
        if (busWrData[4:2] == MODE_HOST) modeQ <= MODE_HOST;
      end
      if (wrCtrlB) begin
        smartEn <= busWrData[SMART_BIT];
        ackAct  <= busWrData[ACKACT_BIT];
      end
      if (wrBaud) baudQ <= busWrData;
      if (strb.setNack) nackQ <= 1'b1;
      else if (strb.clrNack) nackQ <= 1'b0;
      if (strb.loadRx) rxQ <= engRdData;
    end
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int POS = srcPos(i);
    logic enBit, flagBit;
    always_ff @(posedge clk) begin
      if (clrAll) begin
        enBit   <= 1'b0;
        flagBit <= 1'b0;
      end else begin
        if (wrEnSet && busWrData[POS]) enBit <= 1'b1;
        else if (wrEnClr && busWrData[POS]) enBit <= 1'b0;
        if (setVec[i]) flagBit <= 1'b1;
        else if (wrFlag && busWrData[POS]) flagBit <= 1'b0;
      end
    end
    assign enQ[i]   = enBit;
    assign flagQ[i] = flagBit;
  end

  always_comb begin
    enRb   = '0;
    flagRb = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      enRb[srcPos(i)]   = enQ[i];
      flagRb[srcPos(i)] = flagQ[i];
    end
  end

  assign irq       = |(enQ & flagQ);
  assign hostReady = enableQ && (modeQ == MODE_HOST);

  always_comb begin
    busRdData = '0;
    if (busAddr == BUS_AW'(OFF_CTRLA)) begin
      busRdData[4:0] = {modeQ, enableQ, 1'b0};
    end else if (busAddr == BUS_AW'(OFF_CTRLB)) begin
      busRdData[SMART_BIT]  = smartEn;
      busRdData[ACKACT_BIT] = ackAct;
    end else if (busAddr == BUS_AW'(OFF_BAUD)) begin
      busRdData = baudQ;
    end else if (busAddr == BUS_AW'(OFF_ENCLR) || busAddr == BUS_AW'(OFF_ENSET)) begin
      busRdData[BYTE_W-1:0] = enRb;
    end else if (busAddr == BUS_AW'(OFF_FLAG)) begin
      busRdData[BYTE_W-1:0] = flagRb;
    end else if (busAddr == BUS_AW'(OFF_STATUS)) begin
      busRdData[NACK_BIT] = nackQ;
    end else if (busAddr == BUS_AW'(OFF_ADDR)) begin
      busRdData[TGT_AW:0] = {engAddr, engDir};
    end else if (busAddr == BUS_AW'(OFF_DATA)) begin
      busRdData[BYTE_W-1:0] = rxQ;
    end
  end

  p_host_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setHost && !strb.swReset) |=> flagQ[0]);

  p_nack_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setNack && !strb.swReset) |=> nackQ);

  p_mode_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrlA && !busWrData[0] && busWrData[4:2] != MODE_HOST) |=> $stable(modeQ));
endmodule

// File: rtl/i2c_host_regfront.sv
module i2c_host_regfront
  import i2cf_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int TGT_AW = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  output logic              engReq,
  output logic [1:0]        engOp,
  output logic [TGT_AW-1:0] engAddr,
  output logic              engDir,
  output logic [7:0]        engWrData,
  input  logic              engDone,
  input  logic              engNack,
  input  logic [7:0]        engRdData,
  output logic              irq
);
  strobe_t strb;
  logic    hostReady, smartEn, ackAct;

  i2cf_ctrl #(.BUS_AW(BUS_AW), .TGT_AW(TGT_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .hostReady(hostReady), .smartEn(smartEn), .ackAct(ackAct),
    .engDone(engDone), .engNack(engNack), .engReq(engReq), .engOp(engOp),
    .engAddr(engAddr), .engDir(engDir), .engWrData(engWrData), .strb(strb)
  );

  i2cf_datapath #(.BUS_AW(BUS_AW), .TGT_AW(TGT_AW)) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strb(strb), .engAddr(engAddr), .engDir(engDir), .engRdData(engRdData),
    .busRdData(busRdData), .hostReady(hostReady), .smartEn(smartEn), .ackAct(ackAct),
    .irq(irq)
  );
endmodule

// File: tb/i2c_host_regfront_tb.sv
`timescale 1ns/1ps
module i2c_host_regfront_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        engReq, engDir, irq;
  logic [1:0]  engOp;
  logic [9:0]  engAddr;
  logic [7:0]  engWrData;
  logic        engDone, engNack;
  logic [7:0]  engRdData;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_host_regfront u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .busRdData(busRdData), .engReq(engReq), .engOp(engOp),
    .engAddr(engAddr), .engDir(engDir), .engWrData(engWrData), .engDone(engDone),
    .engNack(engNack), .engRdData(engRdData), .irq(irq)
  );

  // engine model: answers each request after a fixed latency
  logic nackNext = 1'b0;
  logic [7:0] rdNext = '0;
  logic active;
  int cnt, opCount;
  logic [1:0] lastOp;
  logic [9:0] lastAddr;
  logic lastDir;
  logic [7:0] lastByte;

  always @(posedge clk) begin
    if (!rstN) begin
      engDone <= 1'b0; engNack <= 1'b0; engRdData <= '0;
      active <= 1'b0; cnt <= 0; opCount <= 0;
      lastOp <= '0; lastAddr <= '0; lastDir <= 1'b0; lastByte <= '0;
    end else begin
      engDone <= 1'b0;
      if (active) begin
        if (engDone) active <= 1'b0;
        else if (cnt == 1) begin
          engDone <= 1'b1; engNack <= nackNext; engRdData <= rdNext;
        end else cnt <= cnt - 1;
      end else if (engReq) begin
        active <= 1'b1; cnt <= 3; opCount <= opCount + 1;
        lastOp <= engOp; lastAddr <= engAddr; lastDir <= engDir; lastByte <= engWrData;
      end
    end
  end

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRdEn = 1'b1;
    #1 d = busRdData;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (10) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectReg(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRead(a, v);
    checkEq(tag, v, exp);
  endtask

  typedef struct packed {
    logic [7:0]  wa;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VTAB [NVEC] = '{
    '{8'h00, 32'h0000_0016, 8'h00, 32'h0000_0016},  // R2 enable + host mode
    '{8'h00, 32'h0000_000E, 8'h00, 32'h0000_0016},  // R2 mode 3 rejected
    '{8'h00, 32'h0000_0014, 8'h00, 32'h0000_0014},  // R2 enable off, mode kept
    '{8'h0C, 32'hA5A5_5A5A, 8'h0C, 32'hA5A5_5A5A},  // R2 baud storage
    '{8'h04, 32'h0004_0100, 8'h04, 32'h0004_0100},  // R8 ack action + smart
    '{8'h04, 32'h0003_0100, 8'h04, 32'h0000_0100},  // R8 command reads 0
    '{8'h04, 32'h0000_0000, 8'h04, 32'h0000_0000},  // R8
    '{8'h16, 32'h0000_0083, 8'h14, 32'h0000_0083},  // R10 set all
    '{8'h14, 32'h0000_0003, 8'h16, 32'h0000_0080},  // R10 clear two
    '{8'h14, 32'h0000_0080, 8'h14, 32'h0000_0000}   // R10 clear last
  };

  initial begin
    int base;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkEq("R1 engReq", {31'd0, engReq}, 32'd0);
    checkEq("R1 irq", {31'd0, irq}, 32'd0);
    expectReg("R1 ctrlA", 8'h00, 32'd0);
    expectReg("R1 ctrlB", 8'h04, 32'd0);
    expectReg("R1 baud", 8'h0C, 32'd0);
    expectReg("R1 flags", 8'h18, 32'd0);
    expectReg("R1 status", 8'h1A, 32'd0);

    // R3 address write while disabled is ignored
    busWrite(8'h24, 32'h0000_00A0);
    settle();
    checkEq("R3 disabled start ignored", opCount, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      busWrite(VTAB[i].wa, VTAB[i].wd);
      busRead(VTAB[i].ra, v);
      checkEq($sformatf("table vector %0d (R2/R8/R10)", i), v, VTAB[i].ex);
    end

    busWrite(8'h00, 32'h0000_0016);

    // R4 start without acknowledge
    nackNext = 1'b1;
    busWrite(8'h24, 32'h0000_00A0);
    settle();
    checkEq("R3 op start", {30'd0, lastOp}, 32'd0);
    checkEq("R3 target address", {22'd0, lastAddr}, 32'h50);
    checkEq("R3 direction", {31'd0, lastDir}, 32'd0);
    expectReg("R4 host flag", 8'h18, 32'h01);
    expectReg("R4 status nack", 8'h1A, 32'h04);
    base = opCount;
    busWrite(8'h28, 32'h0000_0055);
    settle();
    checkEq("R6 data write when idle ignored", opCount, base);

    // R11 / R12 interrupt path
    busWrite(8'h18, 32'h0000_0000);
    expectReg("R11 write 0 keeps flag", 8'h18, 32'h01);
    checkEq("R12 irq off with no enable", {31'd0, irq}, 32'd0);
    busWrite(8'h16, 32'h0000_0001);
    checkEq("R12 irq on", {31'd0, irq}, 32'd1);
    busWrite(8'h16, 32'h0000_0002);
    busWrite(8'h18, 32'h0000_0001);
    expectReg("R11 W1C", 8'h18, 32'h00);
    checkEq("R12 irq off after clear", {31'd0, irq}, 32'd0);
    busWrite(8'h14, 32'h0000_0083);

    // R5 acknowledged write start
    nackNext = 1'b0;
    busWrite(8'h24, 32'h0000_00A0);
    settle();
    expectReg("R5 status cleared", 8'h1A, 32'h00);
    expectReg("R5 host flag", 8'h18, 32'h01);
    busWrite(8'h18, 32'h0000_0083);

    // R6 data write in writing state
    base = opCount;
    busWrite(8'h28, 32'h0000_003C);
    settle();
    checkEq("R6 one op", opCount, base + 1);
    checkEq("R6 op write", {30'd0, lastOp}, 32'd1);
    checkEq("R6 byte", {24'd0, lastByte}, 32'h3C);
    expectReg("R6 host flag", 8'h18, 32'h01);

    // R13 writes during an outstanding op
    base = opCount;
    busWrite(8'h28, 32'h0000_0011);
    busWrite(8'h24, 32'h0000_0067);
    checkEq("R13 request held", {31'd0, engReq}, 32'd1);
    checkEq("R13 op stable", {30'd0, engOp}, 32'd1);
    settle();
    checkEq("R13 second write ignored", opCount, base + 1);
    checkEq("R13 last op write", {30'd0, lastOp}, 32'd1);
    checkEq("R13 byte", {24'd0, lastByte}, 32'h11);

    // R5 / R7 read-direction start
    busWrite(8'h18, 32'h0000_0083);
    rdNext = 8'h5A;
    busWrite(8'h24, 32'h0000_0067);
    settle();
    checkEq("R3 read direction", {31'd0, lastDir}, 32'd1);
    checkEq("R3 read address", {22'd0, lastAddr}, 32'h33);
    expectReg("R3 address readback", 8'h24, 32'h67);
    expectReg("R5 client flag", 8'h18, 32'h02);
    busWrite(8'h18, 32'h0000_0002);
    expectReg("R7 received byte", 8'h28, 32'h5A);
    expectReg("R7 data read sets client flag", 8'h18, 32'h02);

    // R8 command 2 and 1
    rdNext = 8'h77;
    busWrite(8'h04, 32'h0002_0000);
    settle();
    checkEq("R8 cmd2 read op", {30'd0, lastOp}, 32'd2);
    expectReg("R8 cmd2 byte", 8'h28, 32'h77);
    rdNext = 8'hC4;
    busWrite(8'h04, 32'h0001_0000);
    settle();
    checkEq("R8 cmd1 restart", {30'd0, lastOp}, 32'd0);
    checkEq("R8 cmd1 address", {22'd0, lastAddr}, 32'h33);

    // R9 smart mode
    busWrite(8'h04, 32'h0000_0100);
    rdNext = 8'h81;
    base = opCount;
    expectReg("R9 smart read returns held byte", 8'h28, 32'hC4);
    settle();
    checkEq("R9 smart read issues read", opCount, base + 1);
    checkEq("R9 op read", {30'd0, lastOp}, 32'd2);
    expectReg("R9 next byte", 8'h28, 32'h81);
    settle();
    busWrite(8'h04, 32'h0004_0100);
    base = opCount;
    expectReg("R9 nack read byte", 8'h28, 32'h81);
    settle();
    checkEq("R9 smart nack stops", {30'd0, lastOp}, 32'd3);
    checkEq("R9 one op", opCount, base + 1);
    busWrite(8'h18, 32'h0000_0083);
    base = opCount;
    expectReg("R7 idle read", 8'h28, 32'h81);
    settle();
    checkEq("R9 idle after stop", opCount, base);
    expectReg("R7 idle read keeps flags", 8'h18, 32'h00);

    // R8 command 3 and idle commands
    busWrite(8'h04, 32'h0000_0000);
    busWrite(8'h24, 32'h0000_0067);
    settle();
    busWrite(8'h04, 32'h0003_0000);
    settle();
    checkEq("R8 cmd3 stop", {30'd0, lastOp}, 32'd3);
    base = opCount;
    busWrite(8'h04, 32'h0001_0000);
    busWrite(8'h04, 32'h0002_0000);
    settle();
    checkEq("R8 commands in idle issue nothing", opCount, base);

    // R2 software reset
    busWrite(8'h16, 32'h0000_0083);
    busWrite(8'h00, 32'h0000_0001);
    @(negedge clk);
    expectReg("R2 swrst ctrlA", 8'h00, 32'd0);
    expectReg("R2 swrst enables", 8'h16, 32'd0);
    expectReg("R2 swrst baud", 8'h0C, 32'd0);
    expectReg("R2 swrst address", 8'h24, 32'd0);
    checkEq("R2 swrst irq", {31'd0, irq}, 32'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule